// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words as the clock master of a synchronous serial link. It produces the serial clock itself from a baud tick input: each tick moves the clock by half a period. It shifts in 8 or 9 data bits per word from one data input. Finished words go into a two-entry holding FIFO while the next word shifts in, so software can fall up to two words behind before anything is lost.

Two enables control reception. A set/clear pair drives the single-word enable, which clears itself once its word has been received. The continuous enable is a level, and words are received back to back for as long as it is high. If the FIFO is full when a word completes, the word is dropped and an overrun flag is raised. While that flag is set, reception is locked out. The flag is released only when the continuous enable is lowered. The consumer reads the oldest word, with its ninth bit, from the head outputs and removes it with a pop strobe.

The bit clock runs as a state machine with three states: CK_IDLE (stopped, clock low), CK_HIGH (clock high, waiting for the tick that makes the falling edge) and CK_LOW (clock low between bits). The transitions are:
- CK_IDLE to CK_HIGH on a tick while reception is allowed.
- CK_HIGH to CK_LOW on a tick. This is the sampling edge, and it completes the word on the last bit.
- CK_LOW to CK_HIGH on a tick.
- CK_HIGH or CK_LOW to CK_IDLE whenever reception is no longer allowed (abort).

Top module: `sync_master_rx`

## Requirements
- R1: After reset, sclk, single_on, rx_pending and overrun are all 0.
- R2: sclk idles low. Reception is allowed when (cont_en or single_on) is 1 and overrun is 0. While it is allowed, each cycle with baud_tick=1 toggles sclk, and the first tick after an idle period raises sclk. A rising sclk only ever follows a tick.
- R3: sdata is sampled in the cycle in which a tick makes sclk fall. Bits arrive least significant first, so the k-th sample becomes bit k of the word. A word has 8 bits when nine_bit_en=0 and 9 bits when it is 1. head_data carries bits 7..0.
- R4: A pulse on single_set sets single_on, and a pulse on single_clr clears it (set wins if both are high). When a word completes while cont_en=0, single_on clears and sclk stays low afterwards.
- R5: While cont_en=1, words are received back to back with no gap beyond the normal clock half periods.
- R6: With cont_en=1 and single_on=1, completing a word does not clear single_on. Reception continues as in continuous mode.
- R7: A completed word enters the FIFO if it holds fewer than 2 words, or if rd_pop=1 with a non-empty FIFO in the same cycle. The head shows the oldest word. rx_pending is 1 exactly while the FIFO is non-empty, and it falls only after a pop.
- R8: A word that completes while the FIFO is full and no pop happens is discarded, overrun becomes 1, and the FIFO contents stay as they were.
- R9: While overrun=1, sclk stays low and no word enters the FIFO.
- R10: overrun clears only in the cycle after cont_en goes from 1 to 0. It stays set while cont_en stays high.
- R11: The ninth bit is stored with its byte and appears on head_bit9 alongside it, moving on each pop. In 8-bit mode the stored ninth bit is 0.
- R12: Dropping both enables in the middle of a word makes sclk low from the next cycle and discards the partial word without touching the FIFO. The next word starts again from bit 0.
- R13: rd_pop while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle tick, one per serial-clock half period |
| cont_en | input | 1 | Continuous receive enable (level) |
| single_set | input | 1 | Pulse that sets the single-word enable |
| single_clr | input | 1 | Pulse that clears the single-word enable |
| nine_bit_en | input | 1 | 1 selects 9-bit words |
| sdata | input | 1 | Serial data in |
| rd_pop | input | 1 | Removes the head word from the FIFO |
| sclk | output | 1 | Generated serial clock |
| single_on | output | 1 | Current single-word enable |
| rx_pending | output | 1 | FIFO holds at least one word |
| overrun | output | 1 | Overrun lockout flag |
| head_data | output | 8 | Data byte of the oldest word |
| head_bit9 | output | 1 | Ninth bit of the oldest word |

## Verification
A word completion and a pop can land on the same clock edge while the FIFO is full. In that case the pop must free the slot the new word takes, with no overrun. The bench provokes this on purpose: it fills the FIFO, then raises rd_pop exactly on the edge where its own model predicts the last sampling tick. Every cycle it compares head word, ninth bit, pending and overrun against the model's queue, which pops before it pushes. Random pops during continuous reception produce further coincidences of push and pop at lower fill levels.

// File: rtl/smr_pkg.sv
package smr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CK_IDLE,
        CK_HIGH,
        CK_LOW
    } ck_state_t;
endpackage

// File: rtl/smr_bitclk.sv
module smr_bitclk
    import smr_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              baud_tick,
    input  logic              nine_bit,
    input  logic              sdata,
    output logic              sclk,
    output logic              word_done,
    output logic [DATA_W:0]   word_data
);
    localparam int WORD_W = DATA_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    ck_state_t          state, state_nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CNT_W-1:0]   last_idx;
    logic [WORD_W-1:0]  shreg;
    logic               sample;

    assign last_idx = nine_bit ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CK_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            CK_IDLE: if (run && baud_tick) state_nxt = CK_HIGH;
            CK_HIGH: begin
                if (!run)           state_nxt = CK_IDLE;
                else if (baud_tick) state_nxt = CK_LOW;
            end
            CK_LOW: begin
                if (!run)           state_nxt = CK_IDLE;
                else if (baud_tick) state_nxt = CK_HIGH;
            end
            default: state_nxt = CK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sclk      = (state == CK_HIGH);
        sample    = (state == CK_HIGH) && run && baud_tick;
        word_done = sample && (bit_cnt == last_idx);
        for (int i = 0; i < WORD_W; i++) begin
            word_data[i] = (CNT_W'(i) == bit_cnt) ? sdata : shreg[i];
        end
        if (!nine_bit) word_data[DATA_W] = 1'b0;
    end

    // bit counter and shift storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            if (!run || word_done) begin
                bit_cnt <= '0;
            end else if (sample) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (sample) shreg[bit_cnt] <= sdata;
        end
    end
endmodule

// File: rtl/smr_fifo.sv
module smr_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] level;
    logic          pop_ok, push_ok;

    assign empty   = (level == '0);
    assign full    = (level == CW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= ptr_next(wr_ptr);
            end
            if (pop_ok) rd_ptr <= ptr_next(rd_ptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
    import smr_pkg::*;
#(
    parameter int DATA_W     = BYTE_W,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              cont_en,
    input  logic              single_set,
    input  logic              single_clr,
    input  logic              nine_bit_en,
    input  logic              sdata,
    input  logic              rd_pop,
    output logic              sclk,
    output logic              single_on,
    output logic              rx_pending,
    output logic              overrun,
    output logic [DATA_W-1:0] head_data,
    output logic              head_bit9
);
    localparam int WORD_W = DATA_W + 1;

    logic              run;
    logic              word_done;
    logic [WORD_W-1:0] word_data;
    logic [WORD_W-1:0] head_word;
    logic              fifo_empty, fifo_full;
    logic              accept, lost;
    logic              cont_q;

    assign run    = (cont_en || single_on) && !overrun;
    assign accept = word_done && (!fifo_full || (rd_pop && !fifo_empty));
    assign lost   = word_done && !accept;

    smr_bitclk #(.DATA_W(DATA_W)) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .baud_tick (baud_tick),
        .nine_bit  (nine_bit_en),
        .sdata     (sdata),
        .sclk      (sclk),
        .word_done (word_done),
        .word_data (word_data)
    );

    smr_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .pop   (rd_pop),
        .din   (word_data),
        .head  (head_word),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_on <= 1'b0;
            overrun   <= 1'b0;
            cont_q    <= 1'b0;
        end else begin
            cont_q <= cont_en;
            if (single_set)                  single_on <= 1'b1;
            else if (single_clr)             single_on <= 1'b0;
            else if (word_done && !cont_en)  single_on <= 1'b0;
            if (lost)                        overrun <= 1'b1;
            else if (cont_q && !cont_en)     overrun <= 1'b0;
        end
    end

    assign rx_pending = !fifo_empty;
    assign head_data  = head_word[DATA_W-1:0];
    assign head_bit9  = head_word[DATA_W];
endmodule

// File: rtl/smr_chk.sv
module smr_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_tick,
    input logic              cont_en,
    input logic              single_clr,
    input logic              rd_pop,
    input logic              sclk,
    input logic              single_on,
    input logic              rx_pending,
    input logic              overrun,
    input logic [DATA_W-1:0] head_data,
    input logic              head_bit9
);
    AST_SCLK_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(baud_tick)); // R2

    AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(single_on) |-> $past(single_clr || sclk)); // R4

    AST_PENDING_NEEDS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_pending) |-> $past(rd_pop)); // R7

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pending && !rd_pop) |=> ($stable(head_data) && $stable(head_bit9))); // R11

    AST_LOCKOUT_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !sclk); // R9

    AST_OVR_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> ($past(!cont_en) && $past(cont_en, 2))); // R10

    AST_ABORT_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cont_en && !single_on) |-> !sclk); // R12
endmodule

bind sync_master_rx smr_chk #(.DATA_W(DATA_W)) u_smr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .cont_en    (cont_en),
    .single_clr (single_clr),
    .rd_pop     (rd_pop),
    .sclk       (sclk),
    .single_on  (single_on),
    .rx_pending (rx_pending),
    .overrun    (overrun),
    .head_data  (head_data),
    .head_bit9  (head_bit9)
);

// File: tb/sync_master_rx_tb_top.sv
module sync_master_rx_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic cont_en = 1'b0;
    logic single_set = 1'b0;
    logic single_clr = 1'b0;
    logic nine_bit_en = 1'b0;
    logic sdata = 1'b0;
    logic rd_pop = 1'b0;
    logic sclk, single_on, rx_pending, overrun, head_bit9;
    logic [7:0] head_data;

    always #5 clk = ~clk;

    sync_master_rx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cont_en(cont_en),
        .single_set(single_set), .single_clr(single_clr), .nine_bit_en(nine_bit_en),
        .sdata(sdata), .rd_pop(rd_pop), .sclk(sclk), .single_on(single_on),
        .rx_pending(rx_pending), .overrun(overrun), .head_data(head_data),
        .head_bit9(head_bit9)
    );

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // ---------------- reference model ----------------
    logic [8:0] q[$];
    bit         m_sclk = 0, m_single = 0, m_ovr = 0, m_cont_q = 0;
    int         m_nbits = 0;
    logic [8:0] m_word = '0;
    int         m_words = 0;
    int         m_collisions = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_sclk = 0; m_single = 0; m_ovr = 0; m_cont_q = 0; m_nbits = 0;
        end else begin
            bit pop, run, done, lost;
            int len;
            len  = nine_bit_en ? 9 : 8;
            pop  = rd_pop && (q.size() > 0);
            run  = (cont_en || m_single) && !m_ovr;
            done = 0; lost = 0;
            if (pop && q.size() == 2 && run && baud_tick && m_sclk && m_nbits == len - 1)
                m_collisions++;
            if (pop) void'(q.pop_front());
            if (!run) begin
                m_sclk = 0; m_nbits = 0;
            end else if (baud_tick) begin
                if (!m_sclk) m_sclk = 1;
                else begin
                    m_word[m_nbits] = sdata;
                    m_nbits++;
                    m_sclk = 0;
                    if (m_nbits == len) begin
                        done = 1; m_nbits = 0;
                        if (q.size() < 2) begin
                            q.push_back(nine_bit_en ? m_word : {1'b0, m_word[7:0]});
                            m_words++;
                        end else lost = 1;
                    end
                end
            end
            if (single_set)              m_single = 1;
            else if (single_clr)         m_single = 0;
            else if (done && !cont_en)   m_single = 0;
            if (lost)                    m_ovr = 1;
            else if (m_cont_q && !cont_en) m_ovr = 0;
            m_cont_q = cont_en;
        end
    end

    // ---------------- stimulus helpers and per-cycle compare ----------------
    int         tick_div = 2;
    int         tick_cnt = 0;
    bit         dir_mode = 0;
    logic [8:0] pattern = '0;
    int         bit_idx = 0;
    bit         prev_sclk = 0;
    bit         auto_pop = 0;
    bit         pop_collide = 0;
    bit         man_pop = 0;
    logic [15:0] lfsr = 16'hACE1;
    int         sclk_high_cnt = 0;
    bit         cmp_on = 0;

    always @(negedge clk) begin
        #1;
        cycles++;
        if (cmp_on) begin
            chk(sclk === m_sclk, "R2 sclk", int'(sclk), int'(m_sclk));
            chk(single_on === m_single, "R4 single_on", int'(single_on), int'(m_single));
            chk(rx_pending === (q.size() != 0), "R7 rx_pending", int'(rx_pending), int'(q.size() != 0));
            chk(overrun === m_ovr, "R8 overrun", int'(overrun), int'(m_ovr));
            if (q.size() != 0) begin
                chk(head_data === q[0][7:0], "R3 head_data", int'(head_data), int'(q[0][7:0]));
                chk(head_bit9 === q[0][8], "R11 head_bit9", int'(head_bit9), int'(q[0][8]));
            end
        end
        if (sclk) sclk_high_cnt++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_cnt = (tick_cnt >= tick_div - 1) ? 0 : tick_cnt + 1;
        baud_tick = (tick_cnt == tick_div - 1);
        if (dir_mode) begin
            if (prev_sclk && !sclk) bit_idx++;
            sdata = (bit_idx < 9) ? pattern[bit_idx] : 1'b0;
        end else begin
            sdata = lfsr[3];
        end
        prev_sclk = sclk;
        rd_pop = man_pop || (auto_pop && lfsr[7:6] == 2'b00);
        if (pop_collide && q.size() == 2 && baud_tick && m_sclk
            && m_nbits == (nine_bit_en ? 8 : 7))
            rd_pop = 1;
        if (cycles > 150000 && !done_flag) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_single;
        @(negedge clk); single_set = 1;
        @(negedge clk); single_set = 0;
    endtask

    task automatic pop_one;
        @(negedge clk); man_pop = 1;
        @(negedge clk); man_pop = 0;
    endtask

    task automatic drain;
        while (q.size() != 0) pop_one();
        cyc(2);
    endtask

    task automatic directed_word(input logic [8:0] w, input bit nine);
        int start;
        start = m_words;
        nine_bit_en = nine;
        pattern = w;
        bit_idx = 0;
        dir_mode = 1;
        pulse_single();
        while (m_words == start || m_single) @(negedge clk);
        cyc(3);
        dir_mode = 0;
    endtask

    initial begin
        int start, lvl;
        logic [7:0] held;
        cyc(4);
        rst_n = 1;
        @(negedge clk);
        #2;
        chk(sclk === 1'b0 && single_on === 1'b0, "R1 ctrl reset", int'({sclk, single_on}), 0);
        chk(rx_pending === 1'b0 && overrun === 1'b0, "R1 flag reset", int'({rx_pending, overrun}), 0);
        cmp_on = 1;

        // single 8-bit word
        directed_word(9'h0A5, 0);
        chk(head_data === 8'hA5, "R3 lsb-first byte", int'(head_data), 'hA5);
        chk(head_bit9 === 1'b0, "R11 bit9 zero in 8-bit mode", int'(head_bit9), 0);
        chk(single_on === 1'b0, "R4 single self-clear", int'(single_on), 0);
        sclk_high_cnt = 0;
        cyc(20);
        chk(sclk_high_cnt == 0, "R4 clock stopped", sclk_high_cnt, 0);
        pop_one();
        #2;
        chk(rx_pending === 1'b0, "R7 pending after pop", int'(rx_pending), 0);

        // single 9-bit word
        directed_word(9'h1C3, 1);
        chk(head_data === 8'hC3, "R3 nine-bit byte", int'(head_data), 'hC3);
        chk(head_bit9 === 1'b1, "R11 ninth bit stored", int'(head_bit9), 1);
        pop_one();
        nine_bit_en = 0;

        // R13: pop while empty
        pop_one();
        #2;
        chk(rx_pending === 1'b0 && overrun === 1'b0, "R13 empty pop no effect",
            int'({rx_pending, overrun}), 0);
        directed_word(9'h03C, 0);
        chk(head_data === 8'h3C, "R13 next word intact", int'(head_data), 'h3C);
        pop_one();

        // R5: continuous with random pops
        start = m_words;
        auto_pop = 1;
        cont_en = 1;
        cyc(600);
        chk(m_words - start >= 8, "R5 back-to-back words", m_words - start, 8);
        cont_en = 0;
        auto_pop = 0;
        drain();

        // R8/R9/R10: overrun
        tick_div = 1;
        cont_en = 1;
        while (!m_ovr) @(negedge clk);
        cyc(1);
        held = head_data;
        sclk_high_cnt = 0;
        cyc(60);
        chk(overrun === 1'b1, "R10 overrun held while enabled", int'(overrun), 1);
        chk(sclk_high_cnt == 0, "R9 clock held low", sclk_high_cnt, 0);
        chk(head_data === held, "R8 fifo head untouched", int'(head_data), int'(held));
        pulse_single();
        cyc(20);
        chk(overrun === 1'b1, "R10 single_set does not clear", int'(overrun), 1);
        @(negedge clk); single_clr = 1;
        @(negedge clk); single_clr = 0;
        cont_en = 0;
        cyc(2);
        chk(overrun === 1'b0, "R10 cleared by enable drop", int'(overrun), 0);
        lvl = 0;
        while (rx_pending) begin pop_one(); #2; lvl++; end
        chk(lvl == 2, "R8 two words kept", lvl, 2);

        // R7: completion and pop on the same edge with a full FIFO
        tick_div = 2;
        cont_en = 1;
        while (q.size() < 2) @(negedge clk);
        start = m_collisions;
        pop_collide = 1;
        while (m_collisions == start) @(negedge clk);
        pop_collide = 0;
        cont_en = 0;
        cyc(2);
        chk(overrun === 1'b0, "R7 same-edge pop frees slot", int'(overrun), 0);
        chk(q.size() == 2 && rx_pending === 1'b1, "R7 fifo full after swap",
            int'(rx_pending), 1);
        drain();

        // R6: precedence
        pulse_single();
        cont_en = 1;
        auto_pop = 1;
        start = m_words;
        while (m_words - start < 3) @(negedge clk);
        cyc(1);
        chk(single_on === 1'b1, "R6 single kept under continuous", int'(single_on), 1);
        cont_en = 0;
        while (m_single) @(negedge clk);
        cyc(3);
        chk(sclk === 1'b0, "R6 single finishes after drop", int'(sclk), 0);
        auto_pop = 0;
        drain();

        // R12: abort mid-word, then a fresh word
        directed_word(9'h05A, 0);
        cont_en = 1;
        while (m_nbits != 4) @(negedge clk);
        cont_en = 0;
        cyc(1);
        #2;
        chk(sclk === 1'b0, "R12 clock stops on abort", int'(sclk), 0);
        chk(rx_pending === 1'b1 && head_data === 8'h5A, "R12 fifo intact",
            int'(head_data), 'h5A);
        pop_one();
        directed_word(9'h0E7, 0);
        chk(head_data === 8'hE7, "R12 restart from bit 0", int'(head_data), 'hE7);
        pop_one();
        cyc(5);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule